// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command packets stored in system memory and hands every payload word to a downstream command consumer. Each packet begins with one header word. Its upper byte gives the number of payload words that follow the header. Its lower 24 bits give the byte address of the next packet. The block reads memory through a single synchronous read port with one cycle of latency. It offers payload words on a valid/ready stream and stalls for as long as the consumer holds ready low.

While it walks, the block builds an estimate of what the chain costs. Every packet visited contributes a fixed base amount. A packet that carries payload adds a surcharge plus its word count. The walk ends when the address of the next packet has bit 23 set. If the chain keeps going past a configurable packet count, the block treats it as a loop, stops, and raises an error flag. When the walk ends, a one-cycle completion pulse marks the result, and the cost estimate, the start address and the address where the walk stopped stay readable until the next start.

Top module: `dma_chain_walker`

## Requirements
- R1: Header word layout: bits [31:24] hold the payload word count and bits [23:0] hold the byte address of the next packet. The payload words sit at the header byte address + 4, + 8 and so on, and are forwarded in that order.
- R2: The start address is reduced to its low 24 bits. Before each packet is visited, the walk ends if bit 23 of the packet address is set. A start address with bit 23 set therefore forwards no words and reports an estimate of 0.
- R3: The memory word index driven on the read port is bits [20:2] of the byte address, so address bits 21 and above have no effect on which words are read.
- R4: The cost estimate starts at 0 and grows by 10 for every packet visited. A packet with a nonzero count adds a further 5 plus its count.
- R5: A packet whose count is 0 forwards no word and only links to the next packet.
- R6: After NODE_LIMIT (default 8192) packets have been visited, if the next address still lacks bit 23, the walk stops, loopErr goes to 1 and stopAddr holds that next address. A walk that ends normally leaves loopErr at 0, and stopAddr holds the terminating address.
- R7: A word offered with sinkValid stays on sinkData, with sinkValid high, until the cycle in which sinkReady is high. Exactly one word moves per such cycle.
- R8: done is a single-cycle pulse at the end of each walk. cycleEst, startAddrOut (the raw 32-bit start address), stopAddr and loopErr hold their values from that pulse until the next accepted start.
- R9: A start request while busy is high is ignored.
- R10: After reset: busy, done, sinkValid, memRdEn and loopErr are 0, and cycleEst is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Start request, sampled while idle |
| startAddr | input | 32 | Byte address of the first packet |
| memRdEn | output | 1 | Memory read enable |
| memRdAddr | output | 19 | Memory word index (byte address bits [20:2]) |
| memRdData | input | 32 | Read data, valid the cycle after memRdEn |
| sinkValid | output | 1 | Payload word valid |
| sinkReady | input | 1 | Consumer ready |
| sinkData | output | 32 | Payload word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| loopErr | output | 1 | Walk stopped by the packet-count limit |
| stopAddr | output | 24 | Address at which the walk stopped |
| cycleEst | output | 32 | Accumulated cost estimate |
| startAddrOut | output | 32 | Start address of the last accepted walk |

## Verification
The assertions check, on every cycle, the properties that can be seen locally: a stalled word stays stable, done lasts one cycle, the loop flag rises only together with done, no word is offered while the block is idle, and the results do not move between walks. What the bench scenarios alone can show is the end-to-end result: the order and count of forwarded words, the exact cost estimate for a given chain, masking of the start address, the stop address after a normal end and after a loop, and a mid-walk start request being ignored. Those depend on memory contents, which only the bench model knows.

// File: rtl/dma_chain_walker_pkg.sv
package dma_chain_walker_pkg;

  typedef struct packed {
    logic loadStart;
    logic linkNode;
    logic capHeader;
    logic rdHdr;
    logic rdPay;
    logic capWord;
    logic popWord;
    logic finish;
    logic setLoop;
  } walk_ctl_t;

  typedef struct packed {
    logic endAddr;
    logic limitHit;
    logic hdrLenZero;
    logic lastWord;
  } walk_sts_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_HREQ, ST_HCAP, ST_PREQ, ST_PCAP, ST_PSEND, ST_FINISH
  } walk_state_e;

endpackage

// File: rtl/dma_chain_walker_ctrl.sv
module dma_chain_walker_ctrl
  import dma_chain_walker_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  input  logic      sinkReady,
  input  walk_sts_t sts,
  output walk_ctl_t ctl,
  output logic      busy,
  output logic      done,
  output logic      sinkValid
);

  walk_state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (startValid) begin
          ctl.loadStart = 1'b1;
          stateNext     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        // the end marker takes priority over the packet-count limit
        if (sts.endAddr) begin
          ctl.finish = 1'b1;
          stateNext  = ST_FINISH;
        end else if (sts.limitHit) begin
          ctl.finish  = 1'b1;
          ctl.setLoop = 1'b1;
          stateNext   = ST_FINISH;
        end else begin
          ctl.linkNode = 1'b1;
          stateNext    = ST_HREQ;
        end
      end
      ST_HREQ: begin
        ctl.rdHdr = 1'b1;
        stateNext = ST_HCAP;
      end
      ST_HCAP: begin
        ctl.capHeader = 1'b1;
        stateNext     = sts.hdrLenZero ? ST_CHECK : ST_PREQ;
      end
      ST_PREQ: begin
        ctl.rdPay = 1'b1;
        stateNext = ST_PCAP;
      end
      ST_PCAP: begin
        ctl.capWord = 1'b1;
        stateNext   = ST_PSEND;
      end
      ST_PSEND: begin
        if (sinkReady) begin
          ctl.popWord = 1'b1;
          stateNext   = sts.lastWord ? ST_CHECK : ST_PREQ;
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FINISH);
  assign sinkValid = (state == ST_PSEND);

endmodule

// File: rtl/dma_chain_walker_dp.sv
module dma_chain_walker_dp
  import dma_chain_walker_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BYTE_AW    = 21,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 8,
  parameter int EST_W      = 32,
  parameter int NODE_LIMIT = 8192,
  parameter int NODE_COST  = 10,
  parameter int PAY_COST   = 5,
  localparam int WORD_AW   = BYTE_AW - 2,
  localparam int CNT_W     = $clog2(NODE_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  walk_ctl_t          ctl,
  input  logic [DATA_W-1:0]  startAddr,
  input  logic [DATA_W-1:0]  memRdData,
  output walk_sts_t          sts,
  output logic               memRdEn,
  output logic [WORD_AW-1:0] memRdAddr,
  output logic [DATA_W-1:0]  sinkData,
  output logic               loopErr,
  output logic [ADDR_W-1:0]  stopAddr,
  output logic [EST_W-1:0]   cycleEst,
  output logic [DATA_W-1:0]  startAddrOut
);

  logic [ADDR_W-1:0]  nextAddr, curAddr;
  logic [WORD_AW-1:0] rdPtr;
  logic [LEN_W-1:0]   remain;
  logic [CNT_W-1:0]   nodeCount;
  logic [LEN_W-1:0]   hdrLen;
  logic [EST_W-1:0]   nodeCost;

  assign hdrLen   = memRdData[DATA_W-1 -: LEN_W];
  assign nodeCost = (hdrLen == '0) ? EST_W'(NODE_COST)
                                   : EST_W'(NODE_COST + PAY_COST) + EST_W'(hdrLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextAddr     <= '0;
      curAddr      <= '0;
      rdPtr        <= '0;
      remain       <= '0;
      nodeCount    <= '0;
      sinkData     <= '0;
      loopErr      <= 1'b0;
      stopAddr     <= '0;
      cycleEst     <= '0;
      startAddrOut <= '0;
    end else begin
      if (ctl.loadStart) begin
        nextAddr     <= startAddr[ADDR_W-1:0];
        cycleEst     <= '0;
        nodeCount    <= '0;
        startAddrOut <= startAddr;
        loopErr      <= 1'b0;
      end
      if (ctl.linkNode) curAddr <= nextAddr;
      if (ctl.capHeader) begin
        nextAddr  <= memRdData[ADDR_W-1:0];
        remain    <= hdrLen;
        rdPtr     <= curAddr[BYTE_AW-1:2] + WORD_AW'(1);
        cycleEst  <= cycleEst + nodeCost;
        nodeCount <= nodeCount + CNT_W'(1);
      end
      if (ctl.capWord) sinkData <= memRdData;
      if (ctl.popWord) begin
        remain <= remain - LEN_W'(1);
        rdPtr  <= rdPtr + WORD_AW'(1);
      end
      if (ctl.finish)  stopAddr <= nextAddr;
      if (ctl.setLoop) loopErr  <= 1'b1;
    end
  end

  assign memRdEn       = ctl.rdHdr | ctl.rdPay;
  assign memRdAddr     = ctl.rdHdr ? curAddr[BYTE_AW-1:2] : rdPtr;
  assign sts.endAddr    = nextAddr[ADDR_W-1];
  assign sts.limitHit   = (nodeCount == CNT_W'(NODE_LIMIT));
  assign sts.hdrLenZero = (hdrLen == '0);
  assign sts.lastWord   = (remain == LEN_W'(1));

endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
  import dma_chain_walker_pkg::*;
#(
  parameter int NODE_LIMIT = 8192,
  parameter int EST_W      = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic [31:0] startAddr,
  output logic        memRdEn,
  output logic [18:0] memRdAddr,
  input  logic [31:0] memRdData,
  output logic        sinkValid,
  input  logic        sinkReady,
  output logic [31:0] sinkData,
  output logic        busy,
  output logic        done,
  output logic        loopErr,
  output logic [23:0] stopAddr,
  output logic [31:0] cycleEst,
  output logic [31:0] startAddrOut
);

  walk_ctl_t ctl;
  walk_sts_t sts;
  logic [EST_W-1:0] estInt;

  dma_chain_walker_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .sinkReady(sinkReady),
    .sts(sts), .ctl(ctl), .busy(busy), .done(done), .sinkValid(sinkValid)
  );

  dma_chain_walker_dp #(
    .ADDR_W(24), .BYTE_AW(21), .DATA_W(32), .LEN_W(8), .EST_W(EST_W),
    .NODE_LIMIT(NODE_LIMIT), .NODE_COST(10), .PAY_COST(5)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .memRdData(memRdData), .sts(sts), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .sinkData(sinkData), .loopErr(loopErr), .stopAddr(stopAddr),
    .cycleEst(estInt), .startAddrOut(startAddrOut)
  );

  assign cycleEst = 32'(estInt);

endmodule

// File: rtl/dma_chain_walker_chk.sv
module dma_chain_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startValid,
  input logic        busy,
  input logic        done,
  input logic        loopErr,
  input logic        sinkValid,
  input logic        sinkReady,
  input logic [31:0] sinkData,
  input logic        memRdEn,
  input logic [31:0] cycleEst,
  input logic [23:0] stopAddr
);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sinkValid && !sinkReady |=> sinkValid && $stable(sinkData));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  loop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopErr) |-> done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !startValid |=> $stable(cycleEst) && $stable(loopErr) && $stable(stopAddr));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sinkValid && !memRdEn);

  // R7
  single_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && sinkValid));

endmodule

bind dma_chain_walker dma_chain_walker_chk chk_i (.*);

// File: tb/dma_chain_walker_tb_top.sv
module dma_chain_walker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_MAX   = 60000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [31:0] startAddr = '0;
  logic        memRdEn;
  logic [18:0] memRdAddr;
  logic [31:0] memRdData;
  logic        sinkValid;
  logic        sinkReady = 1'b0;
  logic [31:0] sinkData;
  logic        busy, done, loopErr;
  logic [23:0] stopAddr;
  logic [31:0] cycleEst, startAddrOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_walker dut_i (.*);

  logic [31:0] mem [0:4095];
  always_ff @(posedge clk) if (memRdEn) memRdData <= mem[memRdAddr[11:0]];

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [1:0] readyMode = 2'd0;
  int readyCnt = 0;
  int wCount;
  logic [31:0] wSum, wFirst, wLast;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // consumer model: choose ready for the coming edge, then record the transfer
  always @(negedge clk) begin
    logic r;
    readyCnt++;
    case (readyMode)
      2'd0: r = 1'b1;
      2'd1: r = readyCnt[0];
      default: r = (readyCnt[1:0] == 2'd0);
    endcase
    sinkReady = r;
    if (sinkValid && r) begin
      if (wCount == 0) wFirst = sinkData;
      wLast = sinkData;
      wSum  = wSum + sinkData;
      wCount++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL R8 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [31:0] start;
    logic [1:0]  mode;
    logic [31:0] count;
    logic [31:0] sum;
    logic [31:0] first;
    logic [31:0] last;
    logic [31:0] est;
    logic        loop;
    logic [23:0] stop;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0100, 2'd0, 32'd5, 32'h89, 32'h11, 32'h23, 32'd45,    1'b0, 24'h800000},
    '{32'h0000_0100, 2'd1, 32'd5, 32'h89, 32'h11, 32'h23, 32'd45,    1'b0, 24'h800000},
    '{32'h0000_0100, 2'd2, 32'd5, 32'h89, 32'h11, 32'h23, 32'd45,    1'b0, 24'h800000},
    '{32'h0080_0000, 2'd0, 32'd0, 32'h0,  32'h0,  32'h0,  32'd0,     1'b0, 24'h800000},
    '{32'hFF00_0400, 2'd1, 32'd1, 32'h31, 32'h31, 32'h31, 32'd16,    1'b0, 24'hFFFFFF},
    '{32'h0020_0400, 2'd0, 32'd1, 32'h31, 32'h31, 32'h31, 32'd16,    1'b0, 24'hFFFFFF},
    '{32'h0000_0600, 2'd0, 32'd0, 32'h0,  32'h0,  32'h0,  32'd81920, 1'b1, 24'h000600}
  };

  task automatic launch(input logic [31:0] a);
    wCount = 0; wSum = '0; wFirst = '0; wLast = '0;
    @(negedge clk);
    startValid = 1'b1;
    startAddr  = a;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < WAIT_MAX && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
  endtask

  initial begin
    bit seen;
    for (int i = 0; i < 4096; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    mem[12'h040] = 32'h0200_0200;  // packet at 0x100: 2 words, next 0x200
    mem[12'h041] = 32'h11;
    mem[12'h042] = 32'h12;
    mem[12'h080] = 32'h0000_0300;  // packet at 0x200: empty, next 0x300
    mem[12'h0C0] = 32'h0380_0000;  // packet at 0x300: 3 words, end marker
    mem[12'h0C1] = 32'h21;
    mem[12'h0C2] = 32'h22;
    mem[12'h0C3] = 32'h23;
    mem[12'h100] = 32'h01FF_FFFF;  // packet at 0x400: 1 word, end marker
    mem[12'h101] = 32'h31;
    mem[12'h180] = 32'h0000_0600;  // packet at 0x600 links to itself

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done, "R10 busy/done", {30'd0, busy, done}, 32'd0);
    chk(!sinkValid && !memRdEn, "R10 sinkValid/memRdEn", {30'd0, sinkValid, memRdEn}, 32'd0);
    chk(!loopErr && cycleEst == 0, "R10 loopErr/cycleEst", cycleEst, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      readyMode = VECS[v].mode;
      launch(VECS[v].start);
      wait_done(seen);
      chk(seen, "R8 done seen", {31'd0, seen}, 32'd1);
      // R1 R5 words and order; R2 R3 masking; R4 estimate; R6 stop/loop
      chk(wCount == VECS[v].count, "R1 R5 word count", wCount, VECS[v].count);
      chk(wSum == VECS[v].sum, "R1 word sum", wSum, VECS[v].sum);
      chk(wFirst == VECS[v].first && wLast == VECS[v].last, "R1 R7 order", wLast, VECS[v].last);
      chk(cycleEst == VECS[v].est, "R4 estimate", cycleEst, VECS[v].est);
      chk(loopErr == VECS[v].loop, "R6 loopErr", {31'd0, loopErr}, {31'd0, VECS[v].loop});
      chk(stopAddr == VECS[v].stop, "R2 R3 R6 stopAddr", {8'd0, stopAddr}, {8'd0, VECS[v].stop});
      chk(startAddrOut == VECS[v].start, "R8 startAddrOut", startAddrOut, VECS[v].start);
      @(negedge clk);
      chk(!done, "R8 done single pulse", {31'd0, done}, 32'd0);
      repeat (8) @(negedge clk);
      chk(cycleEst == VECS[v].est && !busy, "R8 result held", cycleEst, VECS[v].est);
    end

    // R9: start while busy is ignored
    readyMode = 2'd2;
    launch(32'h0000_0100);
    repeat (4) @(negedge clk);
    startValid = 1'b1;
    startAddr  = 32'h0000_0600;
    @(negedge clk);
    startValid = 1'b0;
    wait_done(seen);
    chk(seen && cycleEst == 32'd45, "R9 estimate after mid-walk start", cycleEst, 32'd45);
    chk(startAddrOut == 32'h100 && !loopErr, "R9 startAddrOut", startAddrOut, 32'h100);
    chk(wCount == 5, "R9 word count", wCount, 32'd5);
    repeat (20) @(negedge clk);
    chk(!busy, "R9 no second walk", {31'd0, busy}, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule